// File: doc/BRIEF.md
# Indirect Address Modify-and-Replace Unit

This block turns any 16-bit word in memory into a self-modifying pointer, so that code needs no index registers. A request names the memory location that holds the pointer. It also gives a modifier and two choices. The first is pre-modification, where the effective address is the word plus the modifier. The second is post-modification, where the effective address is the word as it was read. The modifier comes either from a signed field in the instruction or from the value on top of the stack.

The unit fetches the pointer word over a synchronous memory port with one cycle of read latency. It adds the modifier, wrapping modulo 2^16, and reports the effective address with a one-cycle done pulse. If the request asks for write-back, the unit stores the modified word back into the same location before done. A short instruction form carries a 9-bit location field, so 512 pointer locations are reachable. The field is zero-extended onto the memory address. While a request is in flight the unit is busy and ignores new requests.

Top module: `idx_modify_unit`

## Requirements
- R1: After synchronous reset, busy, done, mem_re and mem_we are all 0.
- R2: An accepted request produces exactly one read strobe (mem_re high for one cycle). Its address is the 9-bit location field zero-extended to 16 bits, and location 511 is reachable.
- R3: With req_pre = 1 (pre-modification), eff_addr equals the stored word plus the modifier.
- R4: With req_pre = 0 (post-modification), eff_addr equals the stored word as read, whatever the modifier.
- R5: With req_wb = 1, the unit issues exactly one write strobe to the same location, with data equal to the stored word plus the modifier, and the location then holds that value.
- R6: With req_wb = 0, the unit issues no write strobe and the location keeps its old value.
- R7: With req_from_stack = 0, the modifier is the 8-bit req_field sign-extended to 16 bits (0x80 means -128, 0xFF means -1).
- R8: With req_from_stack = 1, the modifier is the full 16-bit stack_top, sampled in the cycle the request is accepted. Later changes to stack_top have no effect.
- R9: The addition wraps modulo 2^16 (0xFFFF + 1 gives 0x0000).
- R10: done is a one-cycle pulse. It rises 2 clock edges after the accepting edge without write-back and 3 with write-back. busy is high from the accepting edge through the done cycle and low afterwards.
- R11: A request presented while busy is high is ignored. It causes no extra read or write strobe, and the memory location it names is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_loc | input | 9 | Location of the pointer word |
| req_pre | input | 1 | 1 = pre-modification, 0 = post-modification |
| req_wb | input | 1 | 1 = write the modified word back |
| req_from_stack | input | 1 | 1 = modifier from stack_top, 0 = from req_field |
| req_field | input | 8 | Signed instruction modifier field |
| stack_top | input | 16 | Value on top of the stack |
| busy | output | 1 | Request in flight |
| done | output | 1 | One-cycle completion pulse |
| eff_addr | output | 16 | Effective address, held until the next completion |
| mem_addr | output | 16 | Memory address |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid one cycle after mem_re |

## Verification
The write-back strobe and the arrival of a new request can fall in the same cycle. That cycle is the one where the unit should be finishing one pointer update and must not start another. The bench provokes it by holding req_valid high with a different location for the whole busy window of a write-back transaction. It then judges the result by counting read and write strobes per transaction, by checking the address of each write, and by checking that the second location still holds its old word afterwards.

// File: rtl/idxm_pkg.sv
package idxm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_CALC  = 3'd2,
    ST_WRITE = 3'd3,
    ST_DONE  = 3'd4
  } idxm_state_t;

  typedef struct packed {
    logic pre;
    logic wb;
  } idxm_ctl_t;

endpackage

// File: rtl/idxm_mod_sel.sv
module idxm_mod_sel #(
  parameter int WORD_W  = 16,
  parameter int FIELD_W = 8
) (
  input  logic               from_stack,
  input  logic [FIELD_W-1:0] field,
  input  logic [WORD_W-1:0]  stack_top,
  output logic [WORD_W-1:0]  modv
);

  localparam int EXT_W = (WORD_W > FIELD_W) ? (WORD_W - FIELD_W) : 0;

  logic [WORD_W-1:0] field_ext;

  generate
    if (EXT_W > 0) begin : g_sext
      assign field_ext = {{EXT_W{field[FIELD_W-1]}}, field};
    end else begin : g_trunc
      assign field_ext = field[WORD_W-1:0];
    end
  endgenerate

  always_comb begin
    modv = from_stack ? stack_top : field_ext;
  end

endmodule

// File: rtl/idxm_calc.sv
module idxm_calc #(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0] word,
  input  logic [WORD_W-1:0] modv,
  input  logic              pre,
  output logic [WORD_W-1:0] sum,
  output logic [WORD_W-1:0] eff
);

  always_comb begin
    sum = word + modv;
    eff = pre ? sum : word;
  end

endmodule

// File: rtl/idxm_ctrl.sv
module idxm_ctrl
  import idxm_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int LOC_W  = 9,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [LOC_W-1:0]  req_loc,
  input  idxm_ctl_t         req_ctl,
  input  logic [WORD_W-1:0] req_mod,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic [WORD_W-1:0] calc_sum,
  input  logic [WORD_W-1:0] calc_eff,
  output logic [WORD_W-1:0] calc_word,
  output logic [WORD_W-1:0] calc_mod,
  output logic              calc_pre,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] eff_addr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_re,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_wdata
);

  localparam int PAD_W = ADDR_W - LOC_W;

  idxm_state_t       st;
  logic [LOC_W-1:0]  loc_q;
  logic [WORD_W-1:0] mod_q;
  idxm_ctl_t         ctl_q;
  logic              re_q;
  logic              we_q;
  logic              done_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata_q;
  logic [WORD_W-1:0] eff_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      loc_q   <= '0;
      mod_q   <= '0;
      ctl_q   <= '0;
      re_q    <= 1'b0;
      we_q    <= 1'b0;
      done_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      eff_q   <= '0;
    end else begin
      re_q   <= 1'b0;
      we_q   <= 1'b0;
      done_q <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            loc_q  <= req_loc;
            mod_q  <= req_mod;
            ctl_q  <= req_ctl;
            addr_q <= {{PAD_W{1'b0}}, req_loc};
            re_q   <= 1'b1;
            st     <= ST_READ;
          end
        end
        ST_READ: begin
          st <= ST_CALC;
        end
        ST_CALC: begin
          eff_q   <= calc_eff;
          wdata_q <= calc_sum;
          if (ctl_q.wb) begin
            we_q <= 1'b1;
            st   <= ST_WRITE;
          end else begin
            done_q <= 1'b1;
            st     <= ST_DONE;
          end
        end
        ST_WRITE: begin
          done_q <= 1'b1;
          st     <= ST_DONE;
        end
        ST_DONE: begin
          st <= ST_IDLE;
        end
        default: begin
          st <= ST_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    calc_word = mem_rdata;
    calc_mod  = mod_q;
    calc_pre  = ctl_q.pre;
    busy      = (st != ST_IDLE);
    done      = done_q;
    eff_addr  = eff_q;
    mem_addr  = addr_q;
    mem_re    = re_q;
    mem_we    = we_q;
    mem_wdata = wdata_q;
  end

  AST_RE_SINGLE: assert property (@(posedge clk) disable iff (rst) re_q |=> !re_q) else $error("read strobe longer than one cycle"); // R2
  AST_WE_THEN_DONE: assert property (@(posedge clk) disable iff (rst) we_q |=> done_q) else $error("write not followed by done"); // R5
  AST_NO_WE_WITHOUT_WB: assert property (@(posedge clk) disable iff (rst) (done_q && !ctl_q.wb) |-> !$past(we_q)) else $error("write without write-back"); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done_q |=> !done_q) else $error("done longer than one cycle"); // R10
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst) (busy && !done_q) |=> busy) else $error("busy dropped early"); // R10
  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (rst) (busy && req_valid) |=> $stable(loc_q)) else $error("request taken while busy"); // R11

endmodule

// File: rtl/idx_modify_unit.sv
module idx_modify_unit
  import idxm_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int LOC_W   = 9,
  parameter int ADDR_W  = 16,
  parameter int FIELD_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [LOC_W-1:0]   req_loc,
  input  logic               req_pre,
  input  logic               req_wb,
  input  logic               req_from_stack,
  input  logic [FIELD_W-1:0] req_field,
  input  logic [WORD_W-1:0]  stack_top,
  output logic               busy,
  output logic               done,
  output logic [WORD_W-1:0]  eff_addr,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic               mem_re,
  output logic               mem_we,
  output logic [WORD_W-1:0]  mem_wdata,
  input  logic [WORD_W-1:0]  mem_rdata
);

  logic [WORD_W-1:0] modv;
  logic [WORD_W-1:0] calc_word;
  logic [WORD_W-1:0] calc_mod;
  logic              calc_pre;
  logic [WORD_W-1:0] calc_sum;
  logic [WORD_W-1:0] calc_eff;
  idxm_ctl_t         ctl;

  always_comb begin
    ctl.pre = req_pre;
    ctl.wb  = req_wb;
  end

  idxm_mod_sel #(.WORD_W(WORD_W), .FIELD_W(FIELD_W)) u_mod_sel (
    .from_stack (req_from_stack),
    .field      (req_field),
    .stack_top  (stack_top),
    .modv       (modv)
  );

  idxm_calc #(.WORD_W(WORD_W)) u_calc (
    .word (calc_word),
    .modv (calc_mod),
    .pre  (calc_pre),
    .sum  (calc_sum),
    .eff  (calc_eff)
  );

  idxm_ctrl #(.WORD_W(WORD_W), .LOC_W(LOC_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_loc   (req_loc),
    .req_ctl   (ctl),
    .req_mod   (modv),
    .mem_rdata (mem_rdata),
    .calc_sum  (calc_sum),
    .calc_eff  (calc_eff),
    .calc_word (calc_word),
    .calc_mod  (calc_mod),
    .calc_pre  (calc_pre),
    .busy      (busy),
    .done      (done),
    .eff_addr  (eff_addr),
    .mem_addr  (mem_addr),
    .mem_re    (mem_re),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata)
  );

endmodule

// File: tb/idx_modify_unit_tb.sv
module idx_modify_unit_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [8:0]  req_loc = '0;
  logic        req_pre = 1'b0;
  logic        req_wb = 1'b0;
  logic        req_from_stack = 1'b0;
  logic [7:0]  req_field = '0;
  logic [15:0] stack_top = '0;
  logic        busy, done, mem_re, mem_we;
  logic [15:0] eff_addr, mem_addr, mem_wdata;
  logic [15:0] mem_rdata;

  logic        ld_en = 1'b0;
  logic [9:0]  ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic [15:0] ram [0:1023];
  logic [15:0] sh  [0:511];

  int cyc = 0;
  int n_run = 0;
  int n_fail = 0;
  int re_cnt = 0;
  int we_cnt = 0;
  bit finished = 0;

  typedef struct {
    logic [15:0] eff;
    logic [8:0]  loc;
    logic        wb;
    logic [15:0] after;
    int          lat;
    int          acc;
  } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  idx_modify_unit u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_loc(req_loc),
    .req_pre(req_pre), .req_wb(req_wb), .req_from_stack(req_from_stack),
    .req_field(req_field), .stack_top(stack_top), .busy(busy), .done(done),
    .eff_addr(eff_addr), .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (ld_en) ram[ld_addr] <= ld_data;
    else if (mem_we) ram[mem_addr[9:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= ram[mem_addr[9:0]];
  end

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // monitor: counts strobes and compares each completion with the queue head
  always @(negedge clk) begin
    if (!rst && !ld_en) begin
      if (mem_re) begin
        re_cnt++;
        if (q.size() > 0) chk(mem_addr == {7'd0, q[0].loc}, "R2 read address", mem_addr, {7'd0, q[0].loc});
      end
      if (mem_we) begin
        we_cnt++;
        if (q.size() > 0) begin
          chk(mem_addr == {7'd0, q[0].loc}, "R5 write address", mem_addr, {7'd0, q[0].loc});
          chk(mem_wdata == q[0].after, "R5 write data", mem_wdata, q[0].after);
        end
      end
      if (done) begin
        if (q.size() == 0) chk(0, "R10 unexpected done", 1, 0);
        else begin
          item_t it;
          it = q.pop_front();
          chk(eff_addr == it.eff, "R3/R4 eff_addr", eff_addr, it.eff);
          chk(ram[{1'b0, it.loc}] == it.after, "R5/R6 stored word", ram[{1'b0, it.loc}], it.after);
          chk(re_cnt == 1, "R2/R11 read strobes", re_cnt, 1);
          chk(we_cnt == (it.wb ? 1 : 0), "R5/R6/R11 write strobes", we_cnt, it.wb ? 1 : 0);
          chk(cyc - it.acc == it.lat, "R10 done latency", cyc - it.acc, it.lat);
        end
        re_cnt = 0;
        we_cnt = 0;
      end
    end
  end

  // driver: computes expectation from the shadow copy and pushes it
  task automatic issue(input logic [8:0] loc, input bit pre, input bit wb, input bit stk,
                       input logic [7:0] fld, input logic [15:0] top,
                       input bit spam, input logic [8:0] spam_loc);
    logic [15:0] modv, word, sum;
    item_t it;
    int n;
    modv = stk ? top : {{8{fld[7]}}, fld};
    word = sh[loc];
    sum  = word + modv;
    it.eff   = pre ? sum : word;
    it.loc   = loc;
    it.wb    = wb;
    it.after = wb ? sum : word;
    it.lat   = wb ? 3 : 2;
    if (wb) sh[loc] = sum;
    @(negedge clk);
    req_valid = 1; req_loc = loc; req_pre = pre; req_wb = wb;
    req_from_stack = stk; req_field = fld; stack_top = top;
    @(posedge clk);
    #1;
    it.acc = cyc;
    q.push_back(it);
    @(negedge clk);
    stack_top = ~top;
    req_field = ~fld;
    if (spam) begin
      req_loc = spam_loc; req_wb = 1; req_pre = 1; req_valid = 1;
    end else req_valid = 0;
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
    req_valid = 0;
    chk(n == it.lat + 1, "R10 busy window", n, it.lat + 1);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) sh[i] = 16'(i * 37 + 16'h1200);
    sh[511] = 16'hFFFF;
    sh[40]  = 16'h4040;
    for (int i = 0; i < 512; i++) begin
      @(negedge clk);
      ld_en = 1; ld_addr = 10'(i); ld_data = sh[i];
    end
    @(negedge clk);
    ld_en = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(busy == 0, "R1 busy after reset", busy, 0);
    chk(done == 0, "R1 done after reset", done, 0);
    chk(mem_re == 0, "R1 mem_re after reset", mem_re, 0);
    chk(mem_we == 0, "R1 mem_we after reset", mem_we, 0);

    issue(9'd3, 0, 0, 0, 8'd5, 16'h0, 0, 9'd0);         // R4 R6 R7
    issue(9'd10, 1, 0, 0, 8'h80, 16'h0, 0, 9'd0);       // R3 R7 (-128)
    issue(9'd511, 1, 1, 0, 8'h01, 16'h0, 0, 9'd0);      // R9 R5 R2 loc 511
    issue(9'd20, 0, 1, 1, 8'h00, 16'h0100, 0, 9'd0);    // R8 R4 R5
    issue(9'd20, 1, 1, 1, 8'h00, 16'h8000, 0, 9'd0);    // R8 R3
    issue(9'd30, 1, 1, 0, 8'hFF, 16'h0, 1, 9'd40);      // R11 while write-back
    chk(ram[40] == sh[40], "R11 ignored location unchanged", ram[40], sh[40]);
    for (int k = 0; k < 3; k++) issue(9'd50, 0, 1, 0, 8'd2, 16'h0, 0, 9'd0); // R5 auto-step
    issue(9'd7, 0, 0, 1, 8'h00, 16'h7777, 0, 9'd0);     // R6 R8
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0, "R10 idle after completion", {busy, done}, 0);
    chk(q.size() == 0, "R10 all completions seen", q.size(), 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule